// File: doc/BRIEF.md
# Configurable External Bus Strobe Generator

This block runs one byte or halfword transfer on an external memory or peripheral port. A request carries an address, a direction flag and write data. The block then drives the address and data lines, an active-low chip select and a pair of active-low read and write strobes, and it reports completion with a one-cycle done pulse. On reads that pulse comes with the captured read data. A surrounding sequencer splits wide accesses, checks address ranges and arbitrates ports. It issues a new request whenever the ready output is high.

A single 32-bit timing word shapes every access. Reads and writes each have their own 4-bit strobe delay. Four 2-bit phase fields add cycles around the strobes: a lead-in before chip select, a write hold, a read float and a recovery gap. A wait-enable flag makes the strobe phase stretch until an external ready line is sampled high. The block takes a copy of the timing word when it accepts a request. A word written during a transfer therefore only governs later transfers.

Top module: `ebus_strobe_gen`

## Requirements
- R1: After reset, req_ready is 1, bus_cs_n, bus_rd_n and bus_wr_n are 1, and bus_doe and rsp_done are 0. The timing word resets to 0x0000FFFF, so every timing field is at its maximum and wait-enable (bit 31) is off.
- R2: A strobe only goes low after chip select has been low for at least one cycle. A strobe is only low while chip select is low, and the two strobes are never low together.
- R3: The read strobe stays low for rd_delay+1 cycles and the write strobe for wr_delay+1 cycles. rd_delay is bits [3:0] and wr_delay is bits [7:4]. With the reset timing a write strobe lasts 16 cycles.
- R4: If a request is accepted at a clock edge, chip select goes low lead+1 cycles after that edge, where lead is bits [9:8]. The address is valid while chip select is low. On writes the data lines are driven from the first cycle after acceptance.
- R5: After the write strobe rises, chip select stays low for hold+1 more cycles, where hold is bits [11:10]. The write data stays on the bus and bus_doe stays high until chip select rises. During the strobe the driven data equals the requested write data.
- R6: After the read strobe rises, chip select stays low for float+1 more cycles, where float is bits [13:12]. bus_doe is never high during a read. The read data is the value on bus_din during the last cycle of the read strobe.
- R7: After the done cycle, req_ready rises again recovery+1 cycles later, where recovery is bits [15:14].
- R8: When the timing word's low 16 bits are all zero, chip select is low for exactly 3 cycles per access.
- R9: When bit 31 is set, the strobe is held beyond its delay until bus_wait_rdy is sampled high at a clock edge. When bit 31 is clear, bus_wait_rdy has no effect on the strobe length.
- R10: A timing word written while a transfer is in progress does not change that transfer. The first transfer accepted afterwards uses it.
- R11: rsp_done is high for exactly one cycle, which is the last cycle with chip select low. Chip select is high in the next cycle. rsp_rdata is valid in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 32 | New timing word |
| req_valid | input | 1 | Transfer request, accepted when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External data, outgoing |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | External data, incoming |
| bus_wait_rdy | input | 1 | External device ready, used when wait-enable is set |

## Verification
Two events can fall in the same cycle. One is a timing-word write. The other is the edge where a transfer is accepted or where the running transfer moves between phases. The bench provokes the overlap by writing a new timing word on the cycle right after acceptance, while the slow transfer is still in its lead-in phase. A scoreboard keeps the expected phase lengths computed from the word in force at acceptance. It judges the overlap by comparing those lengths, counted at the pins, for both the running transfer and the next one. A second overlap comes from raising bus_wait_rdy in the same cycle that the strobe counter expires, and again several cycles later. The strobe length measured at the pins must match in each case.

// File: rtl/ebus_pkg.sv
// Shared types and timing-word layout for the external bus strobe generator.
// Assumes a 32-bit timing word; only the fields listed below carry meaning.
package ebus_pkg;

    localparam int CFG_W     = 32;
    localparam int DLY_W     = 4;   // strobe delay field width
    localparam int PH_W      = 2;   // lead / hold / float / recovery width
    localparam int RD_LSB    = 0;
    localparam int WR_LSB    = RD_LSB + DLY_W;
    localparam int LEAD_LSB  = WR_LSB + DLY_W;
    localparam int HOLD_LSB  = LEAD_LSB + PH_W;
    localparam int FLT_LSB   = HOLD_LSB + PH_W;
    localparam int REC_LSB   = FLT_LSB + PH_W;
    localparam int USED_W    = REC_LSB + PH_W;
    localparam int WAIT_BIT  = CFG_W - 1;
    localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'((1 << USED_W) - 1);

    typedef struct packed {
        logic             wait_en;
        logic [DLY_W-1:0] rd_dly;
        logic [DLY_W-1:0] wr_dly;
        logic [PH_W-1:0]  lead;
        logic [PH_W-1:0]  hold;
        logic [PH_W-1:0]  flt;
        logic [PH_W-1:0]  recov;
    } ebus_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEADIN, ST_CSLEAD, ST_STROBE, ST_TAIL, ST_RECOV
    } ebus_state_t;

    // Split a raw timing word into its named fields.
    function automatic ebus_timing_t decode_timing(input logic [CFG_W-1:0] w);
        ebus_timing_t t;
        t.wait_en = w[WAIT_BIT];
        t.rd_dly  = w[RD_LSB   +: DLY_W];
        t.wr_dly  = w[WR_LSB   +: DLY_W];
        t.lead    = w[LEAD_LSB +: PH_W];
        t.hold    = w[HOLD_LSB +: PH_W];
        t.flt     = w[FLT_LSB  +: PH_W];
        t.recov   = w[REC_LSB  +: PH_W];
        return t;
    endfunction

    localparam ebus_timing_t TIMING_RESET = decode_timing(CFG_RESET);

endpackage

// File: rtl/ebus_cfg_reg.sv
// Timing register: holds the decoded timing word, updated on cfg_we.
// Assumes writes may arrive at any time; the sequencer snapshots the value.
module ebus_cfg_reg
    import ebus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output ebus_timing_t       timing_o
);

    ebus_timing_t timing_q;
    logic         unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[WAIT_BIT-1:USED_W];

    // Store the decoded word; reset to the slowest timing.
    always_ff @(posedge clk) begin
        if (!rst_n)      timing_q <= TIMING_RESET;
        else if (cfg_we) timing_q <= decode_timing(cfg_wdata);
    end

    assign timing_o = timing_q;

    AST_RESET_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (timing_q == TIMING_RESET)); // R1

endmodule

// File: rtl/ebus_seq.sv
// Phase sequencer: walks lead-in, chip-select lead, strobe, tail and
// recovery using a snapshot of the timing taken when a request is accepted.
// Assumes requests are only presented while ready is high or are held.
module ebus_seq
    import ebus_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  ebus_timing_t timing_i,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic         wait_rdy,
    output logic         accept_o,
    output logic         capture_o,
    output logic         ready_o,
    output logic         done_o,
    output logic         cs_n_o,
    output logic         rd_n_o,
    output logic         wr_n_o,
    output logic         doe_o
);

    ebus_state_t      st_q, st_d;
    ebus_timing_t     snap_q, snap_d;
    logic             wr_q, wr_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             strobe_end;
    logic             unused_snap_lead;

    assign unused_snap_lead = ^snap_q.lead;
    assign accept_o   = (st_q == ST_IDLE) && req_valid;
    assign strobe_end = (st_q == ST_STROBE) && (cnt_q == '0) &&
                        (!snap_q.wait_en || wait_rdy);

    // Next-state and phase counter selection.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        snap_d = snap_q;
        wr_d   = wr_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) begin
                snap_d = timing_i;
                wr_d   = req_write;
                if (timing_i.lead != '0) begin
                    st_d  = ST_LEADIN;
                    cnt_d = DLY_W'(timing_i.lead) - DLY_W'(1);
                end else begin
                    st_d  = ST_CSLEAD;
                end
            end
            ST_LEADIN: begin
                if (cnt_q == '0) st_d = ST_CSLEAD;
                else             cnt_d = cnt_q - DLY_W'(1);
            end
            ST_CSLEAD: begin
                st_d  = ST_STROBE;
                cnt_d = wr_q ? snap_q.wr_dly : snap_q.rd_dly;
            end
            ST_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - DLY_W'(1);
                end else if (strobe_end) begin
                    st_d  = ST_TAIL;
                    cnt_d = DLY_W'(wr_q ? snap_q.hold : snap_q.flt);
                end
            end
            ST_TAIL: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - DLY_W'(1);
                end else if (snap_q.recov != '0) begin
                    st_d  = ST_RECOV;
                    cnt_d = DLY_W'(snap_q.recov) - DLY_W'(1);
                end else begin
                    st_d  = ST_IDLE;
                end
            end
            ST_RECOV: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - DLY_W'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counter and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            snap_q <= TIMING_RESET;
            wr_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            snap_q <= snap_d;
            wr_q   <= wr_d;
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        ready_o   = (st_q == ST_IDLE);
        done_o    = (st_q == ST_TAIL) && (cnt_q == '0);
        cs_n_o    = !((st_q == ST_CSLEAD) || (st_q == ST_STROBE) || (st_q == ST_TAIL));
        rd_n_o    = !((st_q == ST_STROBE) && !wr_q);
        wr_n_o    = !((st_q == ST_STROBE) && wr_q);
        doe_o     = wr_q && (st_q != ST_IDLE) && (st_q != ST_RECOV);
        capture_o = strobe_end && !wr_q;
    end

    AST_STROBE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n_o) || $fell(wr_n_o)) |-> !$past(cs_n_o)); // R2
    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> (!cs_n_o && (rd_n_o != wr_n_o))); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && cs_n_o)); // R11
    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STROBE) && snap_q.wait_en && !wait_rdy) |=> (!done_o && !cs_n_o)); // R9
    AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !doe_o); // R6
    AST_RECOV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (snap_q.recov != '0)) |=> !ready_o); // R7

endmodule

// File: rtl/ebus_datapath.sv
// Address, write-data and read-data registers for one transfer.
// Assumes load is the accept pulse and capture marks the last strobe cycle.
module ebus_datapath #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Latch request fields on accept and read data at strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= bus_din;
        end
    end

    assign bus_addr  = addr_q;
    assign bus_dout  = wdata_q;
    assign rsp_rdata = rdata_q;

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rsp_rdata)); // R11

endmodule

// File: rtl/ebus_strobe_gen.sv
// Top level: timing register, phase sequencer and datapath for one
// external port. Assumes a sequencer above splits wide transfers.
module ebus_strobe_gen #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ebus_pkg::CFG_W-1:0] cfg_wdata,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       rsp_done,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       bus_cs_n,
    output logic                       bus_rd_n,
    output logic                       bus_wr_n,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [DATA_W-1:0]          bus_dout,
    output logic                       bus_doe,
    input  logic [DATA_W-1:0]          bus_din,
    input  logic                       bus_wait_rdy
);

    ebus_pkg::ebus_timing_t timing;
    logic accept;
    logic capture;

    ebus_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .timing_o  (timing)
    );

    ebus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .timing_i  (timing),
        .req_valid (req_valid),
        .req_write (req_write),
        .wait_rdy  (bus_wait_rdy),
        .accept_o  (accept),
        .capture_o (capture),
        .ready_o   (req_ready),
        .done_o    (rsp_done),
        .cs_n_o    (bus_cs_n),
        .rd_n_o    (bus_rd_n),
        .wr_n_o    (bus_wr_n),
        .doe_o     (bus_doe)
    );

    ebus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .bus_din   (bus_din),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .rsp_rdata (rsp_rdata)
    );

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe)); // R1
    AST_CS_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!bus_cs_n && bus_rd_n && bus_wr_n)); // R11

endmodule

// File: tb/ebus_strobe_gen_tb.sv
`timescale 1ns/1ps
module ebus_strobe_gen_tb;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [DW-1:0] rsp_rdata, bus_dout, bus_din, rd_val = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_wait_rdy = 1'b1;

    always #2 clk = ~clk;

    assign bus_din = !bus_rd_n ? rd_val : 16'hF00F;

    ebus_strobe_gen #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_cfg = 32'h0000_FFFF;

    typedef struct {
        bit          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        int lead, strb, cs, rec, doe;
        string tag;
    } exp_t;
    exp_t q[$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic cfg_write(logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg = w;
    endtask

    // Driver: push expectation from the model word, issue request, steer wait line.
    task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] rv,
                         int stretch, string tag);
        exp_t e;
        int dly, cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        dly    = wr ? int'(m_cfg[7:4]) : int'(m_cfg[3:0]);
        e.wr   = wr; e.addr = a; e.wdata = wd; e.rdata = rv; e.tag = tag;
        e.lead = int'(m_cfg[9:8]);
        e.strb = (m_cfg[31] && stretch > 0) ? stretch : dly + 1;
        e.cs   = 1 + e.strb + 1 + (wr ? int'(m_cfg[11:10]) : int'(m_cfg[13:12]));
        e.rec  = int'(m_cfg[15:14]) + 1;
        e.doe  = wr ? e.lead + e.cs : 0;
        q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; rd_val = rv;
        if (stretch > 0) bus_wait_rdy = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (stretch > 0) begin
            cnt = 0;
            forever begin
                if (!bus_rd_n || !bus_wr_n) cnt++;
                if (cnt >= stretch || rsp_done) break;
                @(negedge clk);
            end
            bus_wait_rdy = 1'b1;
        end
    endtask

    // Monitor: measure each transfer at the pins and compare with the scoreboard.
    bit   active = 0, rcv_wait = 0, seen_cs = 0, post_done = 0;
    int   c_lead, c_cs, c_strb, c_doe, c_lead_bad, c_wbad, c_rec, e_rec;
    exp_t cur;
    initial begin
        forever begin
            @(negedge clk); #1;
            if (post_done) begin
                chk("R11 cs high after done", int'(bus_cs_n), 1);
                chk("R11 done single cycle", int'(rsp_done), 0);
                post_done = 0;
            end
            if (!active) begin
                if (rcv_wait) begin
                    c_rec++;
                    if (req_ready) begin
                        chk("R7 recovery gap", c_rec, e_rec);
                        rcv_wait = 0;
                    end
                end
                if (req_valid && req_ready && q.size() > 0) begin
                    cur = q.pop_front();
                    active = 1; seen_cs = 0;
                    c_lead = 0; c_cs = 0; c_strb = 0; c_doe = 0; c_lead_bad = 0; c_wbad = 0;
                end
            end else begin
                if (bus_cs_n) begin
                    if (!seen_cs) c_lead++;
                end else begin
                    if (!seen_cs) begin
                        seen_cs = 1;
                        if (!bus_rd_n || !bus_wr_n) c_lead_bad++;
                        chk({"R4 address ", cur.tag}, int'(bus_addr), int'(cur.addr));
                    end
                    c_cs++;
                end
                if ((!bus_rd_n || !bus_wr_n) && bus_cs_n) c_lead_bad++;
                if (!bus_rd_n && !bus_wr_n) c_lead_bad++;
                if (!bus_rd_n || !bus_wr_n) c_strb++;
                if (bus_doe) c_doe++;
                if (cur.wr && !bus_wr_n && bus_dout != cur.wdata) c_wbad++;
                if (rsp_done) begin
                    chk({"R4 lead-in ", cur.tag}, c_lead, cur.lead);
                    chk({"R3/R9 strobe width ", cur.tag}, c_strb, cur.strb);
                    chk({"R5/R6/R8 cs low length ", cur.tag}, c_cs, cur.cs);
                    chk({"R5/R6 output enable cycles ", cur.tag}, c_doe, cur.doe);
                    chk({"R2 strobe inside cs ", cur.tag}, c_lead_bad, 0);
                    if (cur.wr) chk({"R5 write data ", cur.tag}, c_wbad, 0);
                    else        chk({"R6 R11 read data ", cur.tag}, int'(rsp_rdata), int'(cur.rdata));
                    active = 0; rcv_wait = 1; c_rec = 0; e_rec = cur.rec; post_done = 1;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 cs_n", int'(bus_cs_n), 1);
        chk("R1 strobes", int'({bus_rd_n, bus_wr_n}), 3);
        chk("R1 doe/done", int'({bus_doe, rsp_done}), 0);
        // R1 R3: reset timing, write strobe 16 cycles
        issue(1, 24'h00_1234, 16'hA55A, 16'h0000, 0, "R3 default write");
        issue(0, 24'h00_4321, 16'h0000, 16'h3C3C, 0, "R6 default read");
        // R8: all low timing bits zero
        cfg_write(32'h0000_0000);
        issue(1, 24'h12_0001, 16'h0F0F, 16'h0000, 0, "R8 fast write");
        issue(0, 24'h12_0002, 16'h0000, 16'h1357, 0, "R8 fast read");
        // R3 R4 R5 R6 R7: asymmetric delays with all phases in use
        cfg_write(32'h0000_D972);
        issue(1, 24'h00_00AA, 16'hBEEF, 16'h0000, 0, "R5 asym write");
        issue(0, 24'h00_00BB, 16'h0000, 16'hCAFE, 0, "R6 asym read");
        issue(0, 24'h00_00BC, 16'h0000, 16'h8001, 0, "R7 back to back");
        // R9: wait flag stretches the strobe
        cfg_write(32'h8000_0001);
        issue(0, 24'h33_0000, 16'h0000, 16'h2468, 6, "R9 wait read");
        issue(1, 24'h33_0001, 16'h7777, 16'h0000, 4, "R9 wait write");
        issue(0, 24'h33_0002, 16'h0000, 16'h1111, 2, "R9 ready at expiry");
        // R9: wait line ignored when flag clear
        cfg_write(32'h0000_0021);
        issue(0, 24'h44_0000, 16'h0000, 16'h9999, 10, "R9 wait ignored read");
        issue(1, 24'h44_0001, 16'h5A5A, 16'h0000, 10, "R9 wait ignored write");
        // R10: timing change mid-transfer
        cfg_write(32'h0000_FFFF);
        issue(1, 24'h55_0000, 16'hD00D, 16'h0000, 0, "R10 slow in flight");
        cfg_write(32'h0000_0000);
        issue(0, 24'h55_0001, 16'h0000, 16'h6060, 0, "R10 next uses new");
        @(negedge clk);
        while (active || rcv_wait || q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule